// File: doc/BRIEF.md
# Stack Pointer and Return Sequencer

This block owns the 8-bit stack pointer of a small CPU and carries out the multi-cycle stack operations that touch internal byte RAM. The CPU hands it one operation at a time: push a byte, pop a byte into a direct address, return from a subroutine, or return from an interrupt. The block then runs through the RAM reads and writes in a fixed order, adjusting the pointer between them, and reports the restored 16-bit program counter for the two return kinds.

The RAM is a single-port synchronous memory: an address presented in one cycle returns its byte on `ram_rdata` in the next, and a write takes effect at the clock edge. The block uses at most one RAM access per cycle. A pop whose destination address matches the stack pointer's own address does not write RAM; it loads the pointer instead, after the pointer's own decrement, so the popped byte is the final pointer value. Return from interrupt additionally pulses a release strobe so the interrupt logic can accept requests at the level just served. No status flags are read or written.

Top module: `stk_ret_seq`

## Requirements
- R1: After reset `sp` equals the parameter `SP_INIT` (default 0x07), `busy`, `done`, `pc_load`, `lvl_release` and `ram_we` are low.
- R2: A push (`req_op`=0, byte in `req_arg`) increments `sp` by one and then writes the byte to RAM at the incremented value.
- R3: A pop (`req_op`=1, destination address in `req_arg`) reads RAM at the current `sp`, decrements `sp`, then writes the read byte to RAM at the destination address when that address differs from `SP_LOC`.
- R4: A pop whose destination equals `SP_LOC` (default 0x81) leaves `sp` equal to the popped byte and writes nothing to RAM.
- R5: A return (`req_op`=2) reads the PC high byte at `sp`, decrements `sp`, reads the PC low byte at the new `sp` and decrements again; `pc_load` pulses for one cycle with `pc_value` = {high, low}. With `sp`=0x0B, RAM[0x0A]=0x23 and RAM[0x0B]=0x01 it ends with `sp`=0x09 and `pc_value`=0x0123.
- R6: A return from interrupt (`req_op`=3) follows the R5 sequence and pulses `lvl_release` in the same cycle as `pc_load`; a plain return never pulses `lvl_release`.
- R7: The pointer wraps modulo 256: a push at 0xFF writes RAM[0x00] and leaves `sp`=0x00, a pop at 0x00 leaves `sp`=0xFF.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle: 2 cycles for a push, 3 for a pop, 4 for either return; a request presented while `busy` is high is ignored.
- R9: Push and pop never pulse `pc_load` or `lvl_release`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request, taken when not busy |
| req_op | input | 2 | 0 push, 1 pop, 2 return, 3 return from interrupt |
| req_arg | input | AW | Push byte or pop destination address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |
| ram_addr | output | AW | RAM address |
| ram_re | output | 1 | RAM read this cycle |
| ram_we | output | 1 | RAM write this cycle |
| ram_wdata | output | AW | RAM write data |
| ram_rdata | input | AW | RAM read data, one cycle after the address |
| sp | output | AW | Stack pointer |
| pc_load | output | 1 | Restored program counter valid |
| pc_value | output | 2*AW | Restored program counter |
| lvl_release | output | 1 | Interrupt level release strobe |

## Verification
The hardest case to reach is a pop into the pointer itself, since its result depends on whether the decrement comes before or after the load, and a wrap across 0xFF/0x00 needs the pointer parked at the top of the address space first. The stimulus builds both from the ports: it pushes 0xFF, then pops that byte into the pointer so the pointer lands on 0xFF, and then pushes and pops across the boundary. The return tests first push a known two-byte frame so the expected counter value and pointer are fixed before the return runs.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_RET  = 2'd2,
    OP_RETI = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_INC,
    ST_PUSH_WR,
    ST_POP_RD,
    ST_POP_DEC,
    ST_POP_WR,
    ST_RET_RDH,
    ST_RET_DECH,
    ST_RET_RDL,
    ST_RET_DECL
  } st_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned AW      = 8,
  parameter logic [AW-1:0] SP_INIT = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] sp_o
);
  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  function automatic logic [AW-1:0] step_down(input logic [AW-1:0] v);
    return v - AW'(1);
  endfunction

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sp_q <= SP_INIT;
    else if (load_i) sp_q <= load_val_i;
    else if (inc_i)  sp_q <= step_up(sp_q);
    else if (dec_i)  sp_q <= step_down(sp_q);
  end

  assign sp_o = sp_q;

  // R2 / R7: increment wraps modulo 2**AW
  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> sp_q == step_up($past(sp_q)));
  // R3 / R7: decrement wraps modulo 2**AW
  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |=> sp_q == step_down($past(sp_q)));
  // R4: a load lands the exact value
  p_load_val_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> sp_q == $past(load_val_i));
  // R8: at most one pointer action per cycle
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_i, dec_i, load_i}));
endmodule

// File: rtl/stk_pc_collect.sv
module stk_pc_collect #(
  parameter int unsigned AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_hi_i,
  input  logic            fire_i,
  input  logic [AW-1:0]   rdata_i,
  output logic            pc_load_o,
  output logic [2*AW-1:0] pc_value_o
);
  logic [AW-1:0] hi_q;
  logic          hi_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      hi_seen_q <= 1'b0;
    end else if (cap_hi_i) begin
      hi_q      <= rdata_i;
      hi_seen_q <= 1'b1;
    end else if (fire_i) begin
      hi_seen_q <= 1'b0;
    end
  end

  assign pc_load_o  = fire_i;
  assign pc_value_o = {hi_q, rdata_i};

  // R5: the low byte is never taken before a high byte was captured
  p_hi_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> hi_seen_q);
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int unsigned   AW     = 8,
  parameter logic [AW-1:0] SP_LOC = 8'h81
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_arg_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] ram_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_re_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_wdata_o,
  output logic          sp_inc_o,
  output logic          sp_dec_o,
  output logic          sp_load_o,
  output logic [AW-1:0] sp_load_val_o,
  output logic          cap_hi_o,
  output logic          pc_fire_o,
  output logic          lvl_release_o
);
  st_e           st_q, st_d;
  op_e           op_q;
  logic [AW-1:0] arg_q;
  logic [AW-1:0] tmp_q;
  logic          accept;
  logic          pop_to_sp;

  assign accept    = (st_q == ST_IDLE) && req_valid_i;
  assign pop_to_sp = (arg_q == SP_LOC);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        unique case (op_e'(req_op_i))
          OP_PUSH: st_d = ST_PUSH_INC;
          OP_POP:  st_d = ST_POP_RD;
          default: st_d = ST_RET_RDH;
        endcase
      end
      ST_PUSH_INC: st_d = ST_PUSH_WR;
      ST_PUSH_WR:  st_d = ST_IDLE;
      ST_POP_RD:   st_d = ST_POP_DEC;
      ST_POP_DEC:  st_d = ST_POP_WR;
      ST_POP_WR:   st_d = ST_IDLE;
      ST_RET_RDH:  st_d = ST_RET_DECH;
      ST_RET_DECH: st_d = ST_RET_RDL;
      ST_RET_RDL:  st_d = ST_RET_DECL;
      ST_RET_DECL: st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_PUSH;
      arg_q <= '0;
      tmp_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q  <= op_e'(req_op_i);
        arg_q <= req_arg_i;
      end
      if (st_q == ST_POP_DEC) tmp_q <= ram_rdata_i;
    end
  end

  always_comb begin
    ram_addr_o    = sp_i;
    ram_re_o      = 1'b0;
    ram_we_o      = 1'b0;
    ram_wdata_o   = arg_q;
    sp_inc_o      = 1'b0;
    sp_dec_o      = 1'b0;
    sp_load_o     = 1'b0;
    sp_load_val_o = tmp_q;
    cap_hi_o      = 1'b0;
    pc_fire_o     = 1'b0;
    lvl_release_o = 1'b0;
    done_o        = 1'b0;
    unique case (st_q)
      ST_PUSH_INC: sp_inc_o = 1'b1;
      ST_PUSH_WR: begin
        ram_we_o = 1'b1;
        done_o   = 1'b1;
      end
      ST_POP_RD:  ram_re_o = 1'b1;
      ST_POP_DEC: sp_dec_o = 1'b1;
      ST_POP_WR: begin
        done_o = 1'b1;
        if (pop_to_sp) sp_load_o = 1'b1;
        else begin
          ram_we_o    = 1'b1;
          ram_addr_o  = arg_q;
          ram_wdata_o = tmp_q;
        end
      end
      ST_RET_RDH:  ram_re_o = 1'b1;
      ST_RET_DECH: begin
        cap_hi_o = 1'b1;
        sp_dec_o = 1'b1;
      end
      ST_RET_RDL:  ram_re_o = 1'b1;
      ST_RET_DECL: begin
        sp_dec_o      = 1'b1;
        pc_fire_o     = 1'b1;
        lvl_release_o = (op_q == OP_RETI);
        done_o        = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);

  // R8: done only inside an operation
  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  // R8: one RAM access per cycle
  p_one_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_re_o && ram_we_o));
  // R2: the push write lands on the already incremented pointer
  p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUSH_INC) |=> ram_we_o && ram_addr_o == $past(sp_i) + AW'(1));
  // R6: the release strobe only comes with a counter load
  p_release_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_release_o |-> pc_fire_o && done_o);
  // R4: a pop into the pointer never writes RAM
  p_sp_pop_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load_o |-> !ram_we_o);
endmodule

// File: rtl/stk_ret_seq.sv
module stk_ret_seq #(
  parameter int unsigned   AW      = 8,
  parameter logic [AW-1:0] SP_INIT = 8'h07,
  parameter logic [AW-1:0] SP_LOC  = 8'h81
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_arg,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_re,
  output logic            ram_we,
  output logic [AW-1:0]   ram_wdata,
  input  logic [AW-1:0]   ram_rdata,
  output logic [AW-1:0]   sp,
  output logic            pc_load,
  output logic [2*AW-1:0] pc_value,
  output logic            lvl_release
);
  logic          sp_inc, sp_dec, sp_load;
  logic [AW-1:0] sp_load_val;
  logic          cap_hi, pc_fire;

  stk_ctrl #(.AW(AW), .SP_LOC(SP_LOC)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid),
    .req_op_i      (req_op),
    .req_arg_i     (req_arg),
    .sp_i          (sp),
    .ram_rdata_i   (ram_rdata),
    .busy_o        (busy),
    .done_o        (done),
    .ram_addr_o    (ram_addr),
    .ram_re_o      (ram_re),
    .ram_we_o      (ram_we),
    .ram_wdata_o   (ram_wdata),
    .sp_inc_o      (sp_inc),
    .sp_dec_o      (sp_dec),
    .sp_load_o     (sp_load),
    .sp_load_val_o (sp_load_val),
    .cap_hi_o      (cap_hi),
    .pc_fire_o     (pc_fire),
    .lvl_release_o (lvl_release)
  );

  stk_ptr #(.AW(AW), .SP_INIT(SP_INIT)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (sp_inc),
    .dec_i      (sp_dec),
    .load_i     (sp_load),
    .load_val_i (sp_load_val),
    .sp_o       (sp)
  );

  stk_pc_collect #(.AW(AW)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_hi_i   (cap_hi),
    .fire_i     (pc_fire),
    .rdata_i    (ram_rdata),
    .pc_load_o  (pc_load),
    .pc_value_o (pc_value)
  );

  // R9: push and pop never produce a counter load
  p_no_pc_on_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_inc || sp_load) |-> !pc_load && !lvl_release);
endmodule

// File: tb/tb_stk_ret_seq.sv
`timescale 1ns/1ps
module tb_stk_ret_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [7:0]  req_arg;
  logic        busy, done, ram_re, ram_we, pc_load, lvl_release;
  logic [7:0]  ram_addr, ram_wdata, ram_rdata, sp;
  logic [15:0] pc_value;

  logic [7:0] mem [256];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          n_busy;
  bit          saw_pc, saw_rel, rel_alone;
  logic [15:0] pc_seen;

  always #4 clk = ~clk;

  stk_ret_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_arg(req_arg),
    .busy(busy), .done(done), .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .sp(sp), .pc_load(pc_load),
    .pc_value(pc_value), .lvl_release(lvl_release)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] arg, input bit poke);
    int guard = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_arg = arg;
    @(negedge clk);
    req_valid = 1'b0;
    n_busy = 0; saw_pc = 0; saw_rel = 0; rel_alone = 0; pc_seen = '0;
    if (poke) begin
      req_valid = 1'b1; req_op = 2'd1; req_arg = 8'h55;
    end
    forever begin
      if (busy) n_busy++;
      if (pc_load) begin saw_pc = 1; pc_seen = pc_value; end
      if (lvl_release) begin saw_rel = 1; if (!pc_load) rel_alone = 1; end
      if (done || guard > 20) break;
      guard++;
      @(negedge clk);
      req_valid = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 sp", sp, 8'h07);
    chk("R1 busy", {busy, done, pc_load, lvl_release, ram_we}, 5'b0);
  endtask

  task automatic t_push_frame;
    logic [7:0] vals [4] = '{8'hAA, 8'hBB, 8'h23, 8'h01};
    for (int i = 0; i < 4; i++) begin
      run_op(2'd0, vals[i], 0);
      chk("R2 sp", sp, 8'h08 + i);
      chk("R2 mem", mem[8'h08 + i], vals[i]);
      chk("R8 push busy", n_busy, 2);
      chk("R9 push no pc", {saw_pc, saw_rel}, 2'b00);
    end
  endtask

  task automatic t_ret;
    run_op(2'd2, 8'h00, 0);
    chk("R5 sp", sp, 8'h09);
    chk("R5 pc_load", saw_pc, 1);
    chk("R5 pc", pc_seen, 16'h0123);
    chk("R6 plain ret no release", saw_rel, 0);
    chk("R8 ret busy", n_busy, 4);
  endtask

  task automatic t_reti;
    run_op(2'd0, 8'h45, 0);
    run_op(2'd0, 8'h67, 0);
    run_op(2'd3, 8'h00, 0);
    chk("R6 sp", sp, 8'h09);
    chk("R6 pc", pc_seen, 16'h6745);
    chk("R6 release", {saw_pc, saw_rel, rel_alone}, 3'b110);
    chk("R8 reti busy", n_busy, 4);
  endtask

  task automatic t_pop_ram;
    run_op(2'd1, 8'h30, 0);
    chk("R3 mem dest", mem[8'h30], 8'hBB);
    chk("R3 sp", sp, 8'h08);
    chk("R8 pop busy", n_busy, 3);
    chk("R9 pop no pc", {saw_pc, saw_rel}, 2'b00);
  endtask

  task automatic t_pop_sp;
    run_op(2'd1, 8'h81, 0);
    chk("R4 sp is popped byte", sp, 8'hAA);
    chk("R4 no ram write at 81", mem[8'h81], 8'h00);
  endtask

  task automatic t_wrap;
    run_op(2'd0, 8'hFF, 0);
    chk("R2 sp", sp, 8'hAB);
    run_op(2'd1, 8'h81, 0);
    chk("R4 sp ff", sp, 8'hFF);
    run_op(2'd0, 8'h5A, 0);
    chk("R7 push wrap sp", sp, 8'h00);
    chk("R7 push wrap mem", mem[8'h00], 8'h5A);
    run_op(2'd1, 8'h40, 0);
    chk("R7 pop wrap sp", sp, 8'hFF);
    chk("R7 pop wrap mem", mem[8'h40], 8'h5A);
  endtask

  task automatic t_ignore_busy;
    run_op(2'd0, 8'h3C, 1);
    chk("R8 busy req ignored sp", sp, 8'h00);
    repeat (3) @(negedge clk);
    chk("R8 busy req ignored idle", busy, 0);
    chk("R8 busy req ignored sp stable", sp, 8'h00);
    chk("R8 no stray write", mem[8'h55], 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_arg = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_frame();
    t_ret();
    t_reti();
    t_pop_ram();
    t_pop_sp();
    t_wrap();
    t_ignore_busy();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule